// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Generator

This block answers the processor's interrupt-acknowledge cycles for a bank of up to 63 peripheral request lines, numbered 1 to 63. Each line has three settings: a 3-bit level, a 3-bit priority and a mask bit. Software programs them through a small register window on a simple 32-bit memory-mapped bus.

An acknowledge is a read into the acknowledge region of that same window. Address bits 4:2 of the read select the level. The block then picks the strongest unmasked pending line at that level. It returns an 8-bit vector equal to a parameterised base plus the line number. If no line qualifies, it returns a fixed spurious vector instead.

The block never touches the requesting peripheral during the acknowledge, so a request stays pending until software clears it at its origin. Setting the base parameter to 64 or to 128 lets two instances serve as the first and second controller of a system.

Top module: `irq_vec_unit`

## Requirements
- R1: Every bus strobe, read or write, is answered by `busReady` high for exactly the following cycle. `busReady` is low after reset and in any cycle not preceded by a strobe.
- R2: A read at address 0xE0 + 4*L is an acknowledge for level L. In the next cycle `busRdata[7:0]` holds VEC_BASE plus the number of the winning line, and `busRdata[31:8]` is zero.
- R3: Among the lines eligible at level L, the one with the numerically largest priority value wins. When priorities are equal, the lowest line number wins.
- R4: A line is eligible at level L only when all of the following hold: its input is high, its mask bit is 0, and its programmed level equals L. A line whose level is programmed to 0 is never eligible.
- R5: When no line is eligible at the requested level, including every acknowledge of level 0, the returned vector is SPUR_VEC (default 24).
- R6: The request inputs are sampled in the strobe cycle. Changing them after that edge does not alter the returned vector.
- R7: An acknowledge clears no state. Repeated acknowledges with unchanged inputs return the same vector.
- R8: Mask registers: 0x00 holds lines 1..31 in bits 31:1, with bit 0 reading 0. 0x04 holds lines 32..63 in bits 31:0. All mask bits reset to 1 and read back as written.
- R9: Configuration words sit at 0x40 + 4*k. Byte j of word k configures line 4k+j: bits [5:3] are the level and bits [2:0] are the priority. Bits 7:6 of each byte and the byte for line 0 read 0. All fields reset to 0.
- R10: 0x08 returns the live inputs of lines 1..31 in bits 31:1, with bit 0 reading 0. 0x0C returns lines 32..63.
- R11: Reads of unmapped addresses return 0. Writes to unmapped addresses, to the pending words or to the acknowledge region change no register.
- R12: With VEC_BASE = 128, the same winner yields vector 128 plus the line number.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busStrobe | input | 1 | One-cycle access request |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte address within the 256-byte window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid while busReady is high |
| busReady | output | 1 | Access completion pulse |
| srcIrq | input | NUM_SRC | Request inputs, bit i-1 is line i |

## Verification
The bench targets several corner cases, each with a distinct symptom of a broken design:
- A priority tie between two lines at the same level shows whether the wrong tie rule is in use; such a design returns the higher-numbered line.
- A line programmed to level 0 that is still pending and unmasked shows whether level-0 lines are wrongly admitted; such a design lets it win, or answers level-0 acknowledges with a real vector.
- Line 62 must map to vector 126, which catches an off-by-one in the base offset.
- Requests are dropped right after the strobe edge. A design that samples late then returns the spurious vector.
- Writes to the pending and acknowledge addresses must leave masks and levels intact.

Random configuration and request patterns, at every level on both a base-64 and a base-128 instance, cover the remaining combinations.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

  // Read-data source selected by the decoder for the cycle after a strobe
  typedef enum logic [2:0] {
    RD_ZERO,
    RD_MASK_LO,
    RD_MASK_HI,
    RD_PEND_LO,
    RD_PEND_HI,
    RD_CFG,
    RD_ACK
  } rd_sel_e;

  // Strobes from the bus decoder to the datapath
  typedef struct packed {
    logic    wrMaskLo;
    logic    wrMaskHi;
    logic    wrCfg;
    logic    capture;
    rd_sel_e rdSel;
    logic [3:0] cfgWord;
    logic [2:0] ackLevel;
  } strobe_t;

  localparam int LVL_W  = 3;
  localparam int PRI_W  = 3;
  localparam int CFG_W  = LVL_W + PRI_W;
  localparam int SLOTS  = 64;          // line 0 is reserved
  localparam int IDX_W  = $clog2(SLOTS);

  localparam logic [5:0] WORD_MASK_LO = 6'h00;
  localparam logic [5:0] WORD_MASK_HI = 6'h01;
  localparam logic [5:0] WORD_PEND_LO = 6'h02;
  localparam logic [5:0] WORD_PEND_HI = 6'h03;

endpackage

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busStrobe,
  input  logic       busWrite,
  input  logic [7:0] busAddr,
  output strobe_t    strb,
  output logic       busReady
);

  logic unusedAddrLsb;
  assign unusedAddrLsb = ^busAddr[1:0];

  logic inAckRegion;
  logic inCfgRegion;
  assign inAckRegion = (busAddr[7:5] == 3'b111);
  assign inCfgRegion = (busAddr[7:6] == 2'b01);

  always_comb begin
    strb          = '0;
    strb.rdSel    = RD_ZERO;
    strb.cfgWord  = busAddr[5:2];
    strb.ackLevel = busAddr[4:2];
    if (busStrobe) begin
      strb.capture = 1'b1;
      if (inAckRegion) begin
        if (!busWrite) strb.rdSel = RD_ACK;
      end else if (inCfgRegion) begin
        if (busWrite) strb.wrCfg = 1'b1;
        else          strb.rdSel = RD_CFG;
      end else begin
        unique case (busAddr[7:2])
          WORD_MASK_LO: begin
            if (busWrite) strb.wrMaskLo = 1'b1;
            else          strb.rdSel    = RD_MASK_LO;
          end
          WORD_MASK_HI: begin
            if (busWrite) strb.wrMaskHi = 1'b1;
            else          strb.rdSel    = RD_MASK_HI;
          end
          WORD_PEND_LO: if (!busWrite) strb.rdSel = RD_PEND_LO;
          WORD_PEND_HI: if (!busWrite) strb.rdSel = RD_PEND_HI;
          default: strb.rdSel = RD_ZERO;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busReady <= 1'b0;
    else       busReady <= busStrobe;
  end

  // R1
  ready_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    busStrobe |=> busReady);

  // R1
  ready_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReady |-> $past(busStrobe));

  // R11
  single_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrMaskLo, strb.wrMaskHi, strb.wrCfg, strb.rdSel == RD_ACK}));

endmodule

// File: rtl/irq_vec_arb.sv
module irq_vec_arb
  import irq_vec_pkg::*;
(
  input  logic [SLOTS-1:0]       cand,
  input  logic [SLOTS*LVL_W-1:0] lvlFlat,
  input  logic [SLOTS*PRI_W-1:0] prioFlat,
  input  logic [LVL_W-1:0]       reqLevel,
  output logic                   hit,
  output logic [IDX_W-1:0]       winIdx
);

  logic [PRI_W-1:0] bestPrio;

  // Ascending scan with a strict comparison: an equal priority never
  // displaces an earlier (lower-numbered) winner.
  always_comb begin
    hit      = 1'b0;
    winIdx   = '0;
    bestPrio = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (cand[i] && (lvlFlat[i*LVL_W +: LVL_W] == reqLevel) &&
          (!hit || (prioFlat[i*PRI_W +: PRI_W] > bestPrio))) begin
        hit      = 1'b1;
        winIdx   = IDX_W'(i);
        bestPrio = prioFlat[i*PRI_W +: PRI_W];
      end
    end
  end

endmodule

// File: rtl/irq_vec_datapath.sv
module irq_vec_datapath
  import irq_vec_pkg::*;
#(
  parameter int NUM_SRC  = 63,
  parameter int VEC_BASE = 64,
  parameter int SPUR_VEC = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic [31:0]        busWdata,
  input  logic [NUM_SRC-1:0] srcIrq,
  output logic [31:0]        busRdata
);

  localparam int CFG_BITS = SLOTS * 8;

  logic [SLOTS-1:0]       maskAll;
  logic [SLOTS-1:0]       pendAll;
  logic [SLOTS-1:0]       cand;
  logic [SLOTS*LVL_W-1:0] lvlFlat;
  logic [SLOTS*PRI_W-1:0] prioFlat;
  logic [CFG_BITS-1:0]    cfgPacked;

  logic unusedWdata;
  assign unusedWdata = ^{busWdata[31:30], busWdata[23:22],
                         busWdata[15:14], busWdata[7:6]};

  for (genvar g = 0; g < SLOTS; g++) begin : g_line
    if (g == 0 || g > NUM_SRC) begin : g_void
      assign maskAll[g]               = 1'b0;
      assign pendAll[g]               = 1'b0;
      assign lvlFlat[g*LVL_W +: LVL_W]  = '0;
      assign prioFlat[g*PRI_W +: PRI_W] = '0;
      assign cfgPacked[g*8 +: 8]      = '0;
      assign cand[g]                  = 1'b0;
    end else begin : g_live
      localparam int  BIT_POS = g % 32;
      localparam bit  IN_HI   = (g >= 32);
      localparam int  BYTE_LN = g % 4;
      localparam logic [3:0] WORD_ID = 4'(g / 4);

      logic             maskQ;
      logic [CFG_W-1:0] cfgQ;
      logic             maskWr;

      assign maskWr = IN_HI ? strb.wrMaskHi : strb.wrMaskLo;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          maskQ <= 1'b1;
          cfgQ  <= '0;
        end else begin
          if (maskWr) maskQ <= busWdata[BIT_POS];
          if (strb.wrCfg && strb.cfgWord == WORD_ID)
            cfgQ <= busWdata[BYTE_LN*8 +: CFG_W];
        end
      end

      assign maskAll[g]                 = maskQ;
      assign pendAll[g]                 = srcIrq[g-1];
      assign lvlFlat[g*LVL_W +: LVL_W]  = cfgQ[CFG_W-1 -: LVL_W];
      assign prioFlat[g*PRI_W +: PRI_W] = cfgQ[PRI_W-1:0];
      assign cfgPacked[g*8 +: 8]        = {2'b00, cfgQ};
      assign cand[g] = pendAll[g] && !maskQ && (cfgQ[CFG_W-1 -: LVL_W] != '0);
    end
  end

  logic             hit;
  logic [IDX_W-1:0] winIdx;

  irq_vec_arb u_arb (
    .cand     (cand),
    .lvlFlat  (lvlFlat),
    .prioFlat (prioFlat),
    .reqLevel (strb.ackLevel),
    .hit      (hit),
    .winIdx   (winIdx)
  );

  logic [7:0]  vecVal;
  logic [31:0] rdNext;

  assign vecVal = hit ? 8'(VEC_BASE + int'(winIdx)) : 8'(SPUR_VEC);

  always_comb begin
    unique case (strb.rdSel)
      RD_MASK_LO: rdNext = maskAll[31:0];
      RD_MASK_HI: rdNext = maskAll[63:32];
      RD_PEND_LO: rdNext = pendAll[31:0];
      RD_PEND_HI: rdNext = pendAll[63:32];
      RD_CFG:     rdNext = cfgPacked[int'(strb.cfgWord)*32 +: 32];
      RD_ACK:     rdNext = {24'h0, vecVal};
      default:    rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             busRdata <= '0;
    else if (strb.capture) busRdata <= rdNext;
  end

  // R2
  ack_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdSel == RD_ACK) |=> ((busRdata[31:8] == '0) &&
      ((busRdata[7:0] == 8'(SPUR_VEC)) ||
       ((busRdata[7:0] > 8'(VEC_BASE)) && (busRdata[7:0] <= 8'(VEC_BASE + NUM_SRC))))));

  // R4
  win_elig_chk: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> (pendAll[winIdx] && !maskAll[winIdx] && (strb.ackLevel != '0) &&
             (lvlFlat[int'(winIdx)*LVL_W +: LVL_W] == strb.ackLevel)));

  // R5
  level0_spur_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdSel == RD_ACK && strb.ackLevel == '0) |=> (busRdata[7:0] == 8'(SPUR_VEC)));

  // R6
  hold_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> $stable(busRdata));

  // R8
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.wrMaskLo || strb.wrMaskHi) |=> $stable(maskAll));

endmodule

// File: rtl/irq_vec_unit.sv
module irq_vec_unit
  import irq_vec_pkg::*;
#(
  parameter int NUM_SRC  = 63,
  parameter int VEC_BASE = 64,
  parameter int SPUR_VEC = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busStrobe,
  input  logic               busWrite,
  input  logic [7:0]         busAddr,
  input  logic [31:0]        busWdata,
  output logic [31:0]        busRdata,
  output logic               busReady,
  input  logic [NUM_SRC-1:0] srcIrq
);

  strobe_t strb;

  irq_vec_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busStrobe (busStrobe),
    .busWrite  (busWrite),
    .busAddr   (busAddr),
    .strb      (strb),
    .busReady  (busReady)
  );

  irq_vec_datapath #(
    .NUM_SRC  (NUM_SRC),
    .VEC_BASE (VEC_BASE),
    .SPUR_VEC (SPUR_VEC)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .busWdata (busWdata),
    .srcIrq   (srcIrq),
    .busRdata (busRdata)
  );

endmodule

// File: tb/test_irq_vec_unit.sv
`timescale 1ns/1ps
module test_irq_vec_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busStrobe = 1'b0;
  logic        busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata, busRdataHi;
  logic        busReady, busReadyHi;
  logic [63:0] irqDrv = '0;

  int checks = 0;
  int fails  = 0;

  logic [63:0] maskM;
  logic [5:0]  cfgM [64];

  always #2 clk = ~clk;

  irq_vec_unit i_irq_vec_unit (
    .clk(clk), .rstN(rstN), .busStrobe(busStrobe), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .busReady(busReady), .srcIrq(irqDrv[63:1])
  );

  irq_vec_unit #(.VEC_BASE(128)) i_irq_vec_unit_hi (
    .clk(clk), .rstN(rstN), .busStrobe(busStrobe), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdataHi),
    .busReady(busReadyHi), .srcIrq(irqDrv[63:1])
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expVec(input int lvl, input logic [63:0] irq, input int base);
    bit found = 0;
    int best = 0;
    int win = 0;
    if (lvl == 0) return 8'd24;
    for (int i = 1; i < 64; i++) begin
      if (irq[i] && !maskM[i] && cfgM[i][5:3] == 3'(lvl) &&
          (!found || int'(cfgM[i][2:0]) > best)) begin
        found = 1; best = int'(cfgM[i][2:0]); win = i;
      end
    end
    return found ? 8'(base + win) : 8'd24;
  endfunction

  function automatic logic [31:0] expCfgWord(input int k);
    logic [31:0] w;
    for (int j = 0; j < 4; j++) w[j*8 +: 8] = {2'b00, cfgM[4*k+j]};
    return w;
  endfunction

  // one bus access; optional change of the request inputs right after capture
  task automatic acc(input logic wr, input logic [7:0] addr, input logic [31:0] wd,
                     input logic scr, input logic [63:0] scrVal,
                     output logic [31:0] rd, output logic [31:0] rdHi, output logic rdy);
    @(negedge clk);
    busStrobe = 1'b1; busWrite = wr; busAddr = addr; busWdata = wd;
    @(posedge clk);
    #1;
    if (scr) irqDrv = scrVal;
    @(negedge clk);
    busStrobe = 1'b0; busWrite = 1'b0;
    rd = busRdata; rdHi = busRdataHi; rdy = busReady;
    if (wr) begin
      if (addr[7:2] == 6'h00) maskM[31:1] = wd[31:1];
      else if (addr[7:2] == 6'h01) maskM[63:32] = wd;
      else if (addr[7:6] == 2'b01) begin
        for (int j = 0; j < 4; j++)
          if (4*int'(addr[5:2]) + j != 0) cfgM[4*int'(addr[5:2]) + j] = wd[j*8 +: 6];
      end
    end
  endtask

  task automatic wr(input logic [7:0] addr, input logic [31:0] wd);
    logic [31:0] a, b; logic r;
    acc(1'b1, addr, wd, 1'b0, '0, a, b, r);
  endtask

  task automatic rdChk(input string req, input logic [7:0] addr, input logic [31:0] exp);
    logic [31:0] a, b; logic r;
    acc(1'b0, addr, '0, 1'b0, '0, a, b, r);
    chk(req, a, exp);
  endtask

  task automatic ackChk(input string req, input int lvl);
    logic [31:0] a, b; logic r;
    acc(1'b0, 8'hE0 + 8'(lvl*4), '0, 1'b0, '0, a, b, r);
    chk(req, a, {24'h0, expVec(lvl, irqDrv, 64)});
    chk({req, " R12"}, b, {24'h0, expVec(lvl, irqDrv, 128)});
  endtask

  // set one line's config byte, keeping the other three in the word
  task automatic setCfg(input int line, input int lvl, input int pri);
    logic [31:0] w;
    int k = line / 4;
    w = expCfgWord(k);
    w[(line%4)*8 +: 8] = {2'b00, 3'(lvl), 3'(pri)};
    wr(8'h40 + 8'(k*4), w);
  endtask

  initial begin
    #700000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] a, b; logic r;
    void'($urandom(32'd20240611));
    maskM = {{63{1'b1}}, 1'b0};
    for (int i = 0; i < 64; i++) cfgM[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state
    chk("R1 ready idle", {31'h0, busReady}, 32'h0);
    rdChk("R8 mask lo reset", 8'h00, 32'hFFFF_FFFE);
    rdChk("R8 mask hi reset", 8'h04, 32'hFFFF_FFFF);
    rdChk("R9 cfg reset", 8'h44, 32'h0);
    irqDrv = 64'hFFFF_FFFF_FFFF_FFFE;
    ackChk("R5 reset ack", 3);

    // R1 ready pulse exactly once
    acc(1'b0, 8'h00, '0, 1'b0, '0, a, b, r);
    chk("R1 ready after strobe", {31'h0, r}, 32'h1);
    @(negedge clk);
    chk("R1 ready drops", {31'h0, busReady}, 32'h0);
    acc(1'b1, 8'h20, 32'h1, 1'b0, '0, a, b, r);
    chk("R1 ready after write", {31'h0, r}, 32'h1);

    // line 62 at level 3 -> 126 / 190
    irqDrv = '0; irqDrv[62] = 1'b1;
    setCfg(62, 3, 5);
    wr(8'h04, 32'hBFFF_FFFF);
    ackChk("R2 line62", 3);
    chk("R2 line62 value", {24'h0, expVec(3, irqDrv, 64)}, 32'd126);
    ackChk("R5 empty level", 2);

    // R3 tie and priority
    setCfg(10, 3, 5); setCfg(40, 3, 5);
    wr(8'h00, 32'hFFFF_FBFE);
    wr(8'h04, 32'hBFFF_FEFF);
    irqDrv[10] = 1'b1; irqDrv[40] = 1'b1;
    ackChk("R3 tie lowest", 3);
    setCfg(40, 3, 7);
    ackChk("R3 higher prio", 3);

    // R4 mask and level 0
    wr(8'h04, 32'hBFFF_FFFF);
    ackChk("R4 masked loser", 3);
    setCfg(10, 0, 7);
    ackChk("R4 level0 excluded", 3);
    ackChk("R5 level0 ack", 0);

    // R6 sampling at strobe
    acc(1'b0, 8'hEC, '0, 1'b1, 64'h0, a, b, r);
    chk("R6 sample at strobe", a, 32'd126);
    ackChk("R6 after drop", 3);
    irqDrv = '0; irqDrv[62] = 1'b1;

    // R7 no clearing
    ackChk("R7 first", 3);
    ackChk("R7 repeat", 3);

    // R10 pending readback
    irqDrv = 64'hA5A5_0000_1234_5679;
    rdChk("R10 pend lo", 8'h08, 32'h1234_5678);
    rdChk("R10 pend hi", 8'h0C, 32'hA5A5_0000);

    // R11 ignored writes and unmapped reads
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'hE4, 32'hFFFF_FFFF);
    rdChk("R11 unmapped read", 8'h20, 32'h0);
    rdChk("R11 mask lo kept", 8'h00, {maskM[31:1], 1'b0});
    rdChk("R11 mask hi kept", 8'h04, maskM[63:32]);
    rdChk("R11 cfg kept", 8'h7C, expCfgWord(15));
    rdChk("R9 cfg word 2", 8'h48, expCfgWord(2));

    // random mix
    for (int n = 0; n < 600; n++) begin
      int op = int'($urandom_range(0, 9));
      if (op < 2) begin
        wr(8'h40 + 8'($urandom_range(0, 15) * 4), $urandom);
      end else if (op < 3) begin
        wr(8'($urandom_range(0, 1) * 4), $urandom | $urandom);
      end else if (op < 4) begin
        int k = int'($urandom_range(0, 15));
        rdChk("R9 cfg random", 8'h40 + 8'(k*4), expCfgWord(k));
      end else begin
        irqDrv = {$urandom & $urandom, $urandom & $urandom};
        irqDrv[0] = 1'b0;
        ackChk("R3 R4 random ack", int'($urandom_range(0, 7)));
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule